// File: doc/BRIEF.md
# Stereo Eight-Times Interpolation Filter

This block raises the sample rate of a two-channel stream of 20-bit two's-complement audio words by a factor of eight. It does this with three doubling stages in series. Each doubling stage splits into two phases: a computed midpoint followed by a pass-through of the sample it brackets. That is the same as inserting one zero between samples and filtering. The first stage has the longest filter (four taps) and works at the lowest rate. The two later stages are two-tap linear interpolators. Results leave as 23-bit words for a noise-shaping modulator downstream.

All arithmetic goes through a single multiply-accumulate unit that is time-shared across stages, phases and channels. A sequencer drives it from a system clock much faster than the sample rate. A frame starts when a right-channel word follows a stored left-channel word. The sequencer then walks the stage cascade depth first and alternates channels on every job. The result is sixteen output strobes per frame: eight per channel, interleaved left, right, left, right.

Top module: `interp8_stereo`

## Requirements
- R1: An active-low reset clears every delay line, the stored left word and the output registers. While reset is held and afterwards, `out_valid` stays 0 and `out_data` reads 0 until a frame produces a result. A frame of zero inputs sent right after reset yields sixteen zero outputs.
- R2: An input word is taken when `in_valid` is 1 and the block is idle. `in_chan` 0 stores the word as the pending left word. `in_chan` 1 starts a frame only if a left word is pending. Words offered while a frame is running are ignored, and so is a right word with no pending left word. Neither changes any later output.
- R3: Each frame emits exactly sixteen one-cycle `out_valid` strobes. `out_chan` alternates 0 (left) and 1 (right), starting with left.
- R4: In the first stage, with a0 the newest of four held samples and a3 the oldest, phase 0 gives -a0 + 9·a1 + 9·a2 - a3 scaled by 1/16. Phase 1 gives a1 unchanged.
- R5: In the second and third stages, with b0 the newest held sample and b1 the one before it, phase 0 gives (b0 + b1)/2 and phase 1 gives b0 unchanged.
- R6: Stage results are produced depth first. Every result of a stage is pushed into the next stage's history at once, and that stage runs its phase 0 then its phase 1 before the earlier stage produces its next result. Per channel the job order is stage1, stage2, stage3, stage3, stage2, stage3, stage3, repeated for the second stage1 phase. The phases of each stage alternate 0, 1.
- R7: Each stage result is rounded as floor((sum + 8)/16) and then saturated to the signed 23-bit range -4194304..4194303. It never wraps.
- R8: An input word enters the first stage multiplied by 8, sign preserved.
- R9: All sixteen outputs of a frame appear within 145 clock cycles of the clock edge that takes the right word. The block is idle again by then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input word strobe |
| in_chan | input | 1 | Channel of the input word: 0 left, 1 right |
| in_data | input | 20 | Two's-complement input sample |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | 1 | Channel of the output sample: 0 left, 1 right |
| out_data | output | 23 | Two's-complement interpolated sample |

## Verification
A wrong history entry shows up within the same frame. Every output is a weighted mix of neighbouring history values, so the sixteen outputs of that frame and of up to three following frames depart from the reference cascade. A sequencing fault, such as a skipped job, a swapped phase or a channel mix-up, changes the count or the left/right order of the strobes within about 140 cycles of the right word. The saturation and rounding corners are reached by alternating full-scale inputs, which push the first-stage sum past the 23-bit range in the next frame.

// File: rtl/interp8_pkg.sv
package interp8_pkg;

    localparam int STAGES = 3;
    localparam int TAPS   = 4;
    localparam int FRAC   = 4;
    localparam int JOBS   = 14;
    localparam int COEF_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WB
    } seq_state_e;

    // Coefficient for one tap of one stage phase, all scaled by 2**FRAC.
    function automatic logic signed [COEF_W-1:0] tap_coef(
        input logic [1:0] stage,
        input logic       phase,
        input logic [1:0] tap
    );
        logic signed [COEF_W-1:0] c;
        c = '0;
        if (stage == 2'd0) begin
            if (!phase)
                c = (tap == 2'd0 || tap == 2'd3) ? -6'sd1 : 6'sd9;
            else
                c = (tap == 2'd1) ? 6'sd16 : 6'sd0;
        end else begin
            if (!phase)
                c = (tap < 2'd2) ? 6'sd8 : 6'sd0;
            else
                c = (tap == 2'd0) ? 6'sd16 : 6'sd0;
        end
        return c;
    endfunction

    // Depth-first job order: returns {stage, phase}.
    function automatic logic [2:0] job_map(input logic [3:0] job);
        logic [3:0] m;
        logic       hi;
        hi = (job >= 4'd7);
        m  = hi ? job - 4'd7 : job;
        case (m)
            4'd0:        return {2'd0, hi};
            4'd1:        return {2'd1, 1'b0};
            4'd4:        return {2'd1, 1'b1};
            4'd2, 4'd5:  return {2'd2, 1'b0};
            default:     return {2'd2, 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/interp8_mac.sv
module interp8_mac #(
    parameter int SMP_W  = 23,
    parameter int COEF_W = 6,
    parameter int ACC_W  = 32,
    parameter int FRAC   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     clr,
    input  logic signed [COEF_W-1:0] coef,
    input  logic signed [SMP_W-1:0]  smp,
    output logic signed [SMP_W-1:0]  result
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (SMP_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (SMP_W - 1));

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } mac_s;

    mac_s mac_d, mac_q;
    logic signed [ACC_W-1:0] coef_x, smp_x, base, rnd;

    always_comb begin
        mac_d  = mac_q;
        coef_x = ACC_W'(coef);
        smp_x  = ACC_W'(smp);
        base   = clr ? '0 : mac_q.acc;
        if (en)
            mac_d.acc = base + coef_x * smp_x;
        // round half up, then clamp into the output range
        rnd = (mac_q.acc + HALF) >>> FRAC;
        if (rnd > MAXV)
            result = MAXV[SMP_W-1:0];
        else if (rnd < MINV)
            result = MINV[SMP_W-1:0];
        else
            result = rnd[SMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mac_q <= '0;
        else        mac_q <= mac_d;
    end

endmodule

// File: rtl/interp8_seq.sv
module interp8_seq
    import interp8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    output logic       busy,
    output logic       chan,
    output logic [1:0] stage,
    output logic       phase,
    output logic [1:0] tap,
    output logic       mac_en,
    output logic       mac_clr,
    output logic       wb
);

    localparam int TW = $clog2(TAPS);
    localparam logic [TW-1:0] LAST_TAP = TW'(TAPS - 1);
    localparam logic [3:0]    LAST_JOB = 4'(JOBS - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [3:0]    job;
        logic          chan;
        logic [TW-1:0] tap;
    } seq_s;

    seq_s seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        busy    = (seq_q.state != ST_IDLE);
        mac_en  = (seq_q.state == ST_RUN);
        mac_clr = (seq_q.tap == '0);
        wb      = (seq_q.state == ST_WB);
        chan    = seq_q.chan;
        tap     = seq_q.tap;
        {stage, phase} = job_map(seq_q.job);
        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_RUN;
                    seq_d.job   = '0;
                    seq_d.chan  = 1'b0;
                    seq_d.tap   = '0;
                end
            end
            ST_RUN: begin
                seq_d.tap = seq_q.tap + 1'b1;
                if (seq_q.tap == LAST_TAP)
                    seq_d.state = ST_WB;
            end
            default: begin
                seq_d.tap = '0;
                if (!seq_q.chan) begin
                    seq_d.chan  = 1'b1;
                    seq_d.state = ST_RUN;
                end else begin
                    seq_d.chan = 1'b0;
                    if (seq_q.job == LAST_JOB) begin
                        seq_d.state = ST_IDLE;
                    end else begin
                        seq_d.job   = seq_q.job + 1'b1;
                        seq_d.state = ST_RUN;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6
    run_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && seq_q.tap == LAST_TAP) |=> wb);

endmodule

// File: rtl/interp8_stereo.sv
module interp8_stereo
    import interp8_pkg::*;
#(
    parameter int IN_W  = 20,
    parameter int OUT_W = 23,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_chan,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic             out_chan,
    output logic [OUT_W-1:0] out_data
);

    localparam int SHIFT = OUT_W - IN_W;

    typedef struct packed {
        logic [STAGES-1:0][1:0][TAPS-1:0][OUT_W-1:0] hist;
        logic [OUT_W-1:0]                            pend;
        logic                                        have_left;
        logic                                        out_valid;
        logic                                        out_chan;
        logic [OUT_W-1:0]                            out_data;
    } top_s;

    top_s top_d, top_q;

    logic                     busy, chan, phase, mac_en, mac_clr, wb, start;
    logic [1:0]               stage, tap;
    logic [OUT_W-1:0]         scaled;
    logic signed [COEF_W-1:0] coef;
    logic signed [OUT_W-1:0]  smp, result;

    assign start  = !busy && in_valid && in_chan && top_q.have_left;
    assign scaled = {in_data, {SHIFT{1'b0}}};
    assign coef   = tap_coef(stage, phase, tap);
    assign smp    = $signed(top_q.hist[stage][chan][tap]);

    interp8_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .chan    (chan),
        .stage   (stage),
        .phase   (phase),
        .tap     (tap),
        .mac_en  (mac_en),
        .mac_clr (mac_clr),
        .wb      (wb)
    );

    interp8_mac #(
        .SMP_W  (OUT_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W),
        .FRAC   (FRAC)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mac_en),
        .clr    (mac_clr),
        .coef   (coef),
        .smp    (smp),
        .result (result)
    );

    always_comb begin
        top_d           = top_q;
        top_d.out_valid = 1'b0;
        if (!busy && in_valid) begin
            if (!in_chan) begin
                top_d.pend      = scaled;
                top_d.have_left = 1'b1;
            end else if (top_q.have_left) begin
                top_d.hist[0][0] = {top_q.hist[0][0][TAPS-2:0], top_q.pend};
                top_d.hist[0][1] = {top_q.hist[0][1][TAPS-2:0], scaled};
                top_d.have_left  = 1'b0;
            end
        end
        if (wb) begin
            if (stage == 2'd0)
                top_d.hist[1][chan] = {top_q.hist[1][chan][TAPS-2:0], result};
            else if (stage == 2'd1)
                top_d.hist[2][chan] = {top_q.hist[2][chan][TAPS-2:0], result};
            else begin
                top_d.out_valid = 1'b1;
                top_d.out_chan  = chan;
                top_d.out_data  = result;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign out_valid = top_q.out_valid;
    assign out_chan  = top_q.out_chan;
    assign out_data  = top_q.out_data;

    // channel of the most recent output, for the ordering check
    logic prev_chan_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_chan_q <= 1'b1;
        else if (out_valid) prev_chan_q <= out_chan;
    end

    // R3
    lr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan != prev_chan_q));

    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && in_valid) |=> $stable(top_q.hist[0]));

endmodule

// File: tb/tb_interp8_stereo.sv
module tb_interp8_stereo;

    typedef struct {
        bit     ch;
        longint val;
        string  tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_chan = 1'b0;
    logic [19:0] in_data = '0;
    logic        out_valid, out_chan;
    logic [22:0] out_data;

    int     n_chk = 0;
    int     n_fail = 0;
    exp_t   exp_q[$];
    longint mh[3][2][4];

    // job order from R6: stage and phase per job
    int js[14] = '{0, 1, 2, 2, 1, 2, 2, 0, 1, 2, 2, 1, 2, 2};
    int jp[14] = '{0, 0, 0, 1, 1, 0, 1, 1, 0, 0, 1, 1, 0, 1};

    always #10 clk = ~clk;

    interp8_stereo dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_chan   (in_chan),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_data)
    );

    function automatic longint cf(int s, int p, int k);
        if (s == 0) begin
            if (p == 0) return (k == 0 || k == 3) ? -1 : 9;   // R4
            return (k == 1) ? 16 : 0;
        end
        if (p == 0) return (k < 2) ? 8 : 0;                  // R5
        return (k == 0) ? 16 : 0;
    endfunction

    function automatic longint rs(longint acc);              // R7
        longint t;
        t = (acc + 8) >>> 4;
        if (t > 4194303) t = 4194303;
        if (t < -4194304) t = -4194304;
        return t;
    endfunction

    task automatic push_hist(int s, int c, longint v);
        for (int k = 3; k > 0; k--) mh[s][c][k] = mh[s][c][k-1];
        mh[s][c][0] = v;
    endtask

    task automatic model_frame(int l, int r, string tag);
        push_hist(0, 0, longint'(l) * 8);                    // R8
        push_hist(0, 1, longint'(r) * 8);
        for (int j = 0; j < 14; j++) begin
            for (int c = 0; c < 2; c++) begin
                longint acc;
                longint res;
                exp_t   e;
                acc = 0;
                for (int k = 0; k < 4; k++) acc += cf(js[j], jp[j], k) * mh[js[j]][c][k];
                res = rs(acc);
                if (js[j] < 2) push_hist(js[j] + 1, c, res);
                else begin
                    e.ch = bit'(c); e.val = res; e.tag = tag;
                    exp_q.push_back(e);
                end
            end
        end
    endtask

    task automatic frame_end_check(string tag);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: outputs missing at frame end, actual pending %0d expected 0", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic send_frame(int l, int r, string tag, bit stray);
        model_frame(l, r, tag);
        @(negedge clk); in_valid = 1'b1; in_chan = 1'b0; in_data = l[19:0];
        @(negedge clk); in_chan = 1'b1; in_data = r[19:0];
        @(negedge clk); in_valid = 1'b0;
        if (stray) begin
            // R2: words offered while the frame is running
            repeat (20) @(negedge clk);
            in_valid = 1'b1; in_chan = 1'b0; in_data = 20'h5A5A5;
            @(negedge clk); in_chan = 1'b1; in_data = 20'hA0F0F;
            @(negedge clk); in_valid = 1'b0;
        end
        repeat (150) @(negedge clk);
        frame_end_check({"R3 R9 ", tag});
    endtask

    task automatic lone_right();
        // R2: right word with no pending left word
        @(negedge clk); in_valid = 1'b1; in_chan = 1'b1; in_data = 20'h3FFFF;
        @(negedge clk); in_valid = 1'b0;
        repeat (150) @(negedge clk);
        frame_end_check("R2 lone right");
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 23'd0) begin
            n_fail++;
            $display("FAIL R1: during reset valid=%0b data=%0d expected 0 0", out_valid, out_data);
        end
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 2; c++)
                for (int k = 0; k < 4; k++) mh[s][c][k] = 0;
        exp_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_data !== 23'd0) begin
            n_fail++;
            $display("FAIL R1: after reset valid=%0b data=%0d expected 0 0", out_valid, out_data);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 R3: unexpected output ch=%0b data=%0d expected none", out_chan, $signed(out_data));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (out_chan !== e.ch || longint'($signed(out_data)) != e.val) begin
                    n_fail++;
                    $display("FAIL %s R4 R5 R6: ch=%0b data=%0d expected ch=%0b data=%0d",
                             e.tag, out_chan, $signed(out_data), e.ch, e.val);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        apply_reset();
        send_frame(0, 0, "R1 silent", 1'b0);
        // impulse and decay
        send_frame(1000, -2000, "R4 impulse", 1'b0);
        send_frame(0, 0, "R5 tail", 1'b0);
        send_frame(0, 0, "R6 tail", 1'b0);
        send_frame(0, 0, "R6 tail", 1'b0);
        // full-scale steps, scaling by 8
        send_frame(524287, -524288, "R8 scale", 1'b0);
        send_frame(524287, -524288, "R8 scale", 1'b0);
        // alternating extremes drive the first stage into saturation
        send_frame(-524288, 524287, "R7 sat", 1'b0);
        send_frame(524287, -524288, "R7 sat", 1'b0);
        send_frame(524287, -524288, "R7 sat", 1'b0);
        send_frame(-524288, 524287, "R7 sat", 1'b0);
        send_frame(-524288, 524287, "R7 sat", 1'b0);
        // ignored inputs
        send_frame(12345, -54321, "R2 busy", 1'b1);
        lone_right();
        send_frame(-7777, 3333, "R2 after", 1'b0);
        send_frame(250000, -131071, "R3 ramp", 1'b0);
        // reset clears history
        apply_reset();
        send_frame(0, 0, "R1 cleared", 1'b0);
        send_frame(100, 200, "R1 restart", 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule